// File: doc/BRIEF.md
# Receive FIFO with Error-Count Status Register

This block sits between the receive shifter of a serial port and the CPU. It buffers up to sixteen received bytes. Each byte carries two tags: one for a parity error and one for a framing error. The block keeps live counts of how many buffered bytes carry each tag. It also holds six event flags in one status word, which the CPU reads over a simple strobe bus. The transmit and receive controllers raise the flags with one-cycle set pulses.

Software cannot set a flag. A flag clears only through a two-step handshake: the CPU first reads the status word while the flag is 1, then writes 0 to that flag's bit. A write of 0 made without that earlier read is ignored. Because of this, an event that arrives between the CPU's read and its write is never lost.

The status word is a pure function of state. `reg_rdata` shows it at all times, and `reg_rd` marks the cycles in which the CPU is taken to have read it. `pop_data` shows the oldest byte, and `pop_req` removes that byte at the next clock edge.

Top module: `rx_fifo_status`

## Requirements
- R1: The FIFO holds up to DEPTH (16) entries in arrival order. `pop_data` shows the oldest byte, or 0 when the FIFO is empty. A push while full is dropped, even when a pop happens in the same cycle. A pop while empty changes nothing.
- R2: Status bits 15..12 give the number of held entries tagged with a parity error, and bits 11..8 give the number with a framing error. Both counts are taken modulo 16, so sixteen tagged entries read as 0.
- R3: Status bit 3 shows the framing tag of the oldest entry and bit 2 shows its parity tag. Both read 0 when the FIFO is empty.
- R4: `flag_set[5]` sets bit 7, `flag_set[4]` sets bit 6, `flag_set[3]` sets bit 5, `flag_set[2]` sets bit 4, `flag_set[1]` sets bit 1 and `flag_set[0]` sets bit 0. The flag reads 1 from the next cycle.
- R5: A register write never sets a flag. It never changes bits 15..8, and it never changes bits 3..2.
- R6: A flag clears in the cycle after a write that has 0 in its bit, but only if a read strobe has seen that flag as 1 since it was last set. Any other write leaves the flag as it is.
- R7: A set pulse in the same cycle as a clearing write wins, so the flag stays 1. A set pulse also cancels any earlier read, and a new read is then needed before the flag can be cleared.
- R8: After reset the status word reads 0x0060, which means bits 6 and 5 are 1 and all others are 0. `pop_data` reads 0.
- R9: When a push and a pop are both accepted in one cycle, both take effect. The counts then reflect the removal of the old entry and the addition of the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push a received byte |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity-error tag of the pushed byte |
| push_ferr | input | 1 | Framing-error tag of the pushed byte |
| pop_req | input | 1 | Remove the oldest byte at the next edge |
| pop_data | output | 8 | Oldest byte, or 0 when empty |
| flag_set | input | 6 | One-cycle set pulses for the six event flags |
| reg_rd | input | 1 | CPU read strobe for the status word |
| reg_wr | input | 1 | CPU write strobe for the status word |
| reg_wdata | input | 16 | CPU write data |
| reg_rdata | output | 16 | Status word |

## Verification
The bench builds the block with the default DEPTH of 16. This makes both 4-bit counts wrap exactly when the FIFO is full of tagged bytes. A directed fill of sixteen bytes tagged with both errors checks that the counts wrap to zero and that a seventeenth push is dropped. Random traffic then mixes simultaneous push and pop, set pulses, reads and writes. Across that traffic, a set pulse often lands in the same cycle as an armed clearing write, and it also lands after a read but before the write.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

  localparam int RXFS_BYTE_W    = 8;
  localparam int RXFS_NUM_FLAGS = 6;

  typedef struct packed {
    logic                   perr;
    logic                   ferr;
    logic [RXFS_BYTE_W-1:0] data;
  } rxfs_entry_t;

  // flag index inside the flag vector
  typedef enum int {
    FL_DR   = 0,
    FL_RDF  = 1,
    FL_BRK  = 2,
    FL_TDFE = 3,
    FL_TEND = 4,
    FL_ER   = 5
  } rxfs_flag_e;

  // reset value of flag i
  function automatic logic flag_rst_val(input int i);
    return (i == FL_TDFE) || (i == FL_TEND);
  endfunction

  // bit position of flag i inside the low status byte
  function automatic int flag_reg_bit(input int i);
    return (i < 2) ? i : i + 2;
  endfunction

endpackage

// File: rtl/rxfs_fifo.sv
module rxfs_fifo
  import rxfs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  rxfs_entry_t push_entry,
  input  logic        pop_req,
  output rxfs_entry_t head_entry,
  output logic        push_acc,
  output logic        pop_acc,
  output logic        empty,
  output logic        full
);

  localparam int AW = $clog2(DEPTH);

  rxfs_entry_t      mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign push_acc = push_valid && !full;
  assign pop_acc  = pop_req && !empty;

  always_comb begin
    if (empty) head_entry = '0;
    else       head_entry = mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr[AW-1:0]] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_ptr + 1'b1;
      if (pop_acc)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/rxfs_err_count.sv
module rxfs_err_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  // modulo-2^CNT_W step; a full FIFO of tagged entries wraps to zero
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic inc_i,
                                                input logic dec_i);
    logic [CNT_W-1:0] nxt;
    nxt = cur;
    if (inc_i) nxt = nxt + 1'b1;
    if (dec_i) nxt = nxt - 1'b1;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_step(count, inc, dec);
  end

endmodule

// File: rtl/rxfs_flag.sv
module rxfs_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_bit,
  output logic flag,
  output logic arm,
  output logic clear_ev
);

  // a clearing write needs a prior read of 1; a set pulse wins
  assign clear_ev = wr_strobe && !wr_bit && arm && !set_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= RST_VAL;
      arm  <= 1'b0;
    end else if (set_pulse) begin
      flag <= 1'b1;
      arm  <= 1'b0;
    end else if (clear_ev) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (rd_strobe && flag) begin
      arm  <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rxfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH),
  localparam int REG_W = 2 * CNT_W + 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  logic [RXFS_BYTE_W-1:0] push_data,
  input  logic                   push_perr,
  input  logic                   push_ferr,
  input  logic                   pop_req,
  output logic [RXFS_BYTE_W-1:0] pop_data,
  input  logic [RXFS_NUM_FLAGS-1:0] flag_set,
  input  logic                   reg_rd,
  input  logic                   reg_wr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata
);

  rxfs_entry_t push_entry;
  rxfs_entry_t head_entry;
  logic        push_acc;
  logic        pop_acc;
  logic        fifo_empty;
  logic        fifo_full;

  assign push_entry = '{perr: push_perr, ferr: push_ferr, data: push_data};

  rxfs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_entry (push_entry),
    .pop_req    (pop_req),
    .head_entry (head_entry),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc),
    .empty      (fifo_empty),
    .full       (fifo_full)
  );

  assign pop_data = head_entry.data;

  // error counters: index 0 parity, index 1 framing
  logic [CNT_W-1:0] err_cnt [2];
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] fer_cnt;

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic in_tag;
    logic out_tag;
    assign in_tag  = (k == 0) ? push_entry.perr : push_entry.ferr;
    assign out_tag = (k == 0) ? head_entry.perr : head_entry.ferr;
    rxfs_err_count #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (push_acc && in_tag),
      .dec   (pop_acc && out_tag),
      .count (err_cnt[k])
    );
  end

  assign per_cnt = err_cnt[0];
  assign fer_cnt = err_cnt[1];

  // event flags
  logic [RXFS_NUM_FLAGS-1:0] flag_q;
  logic [RXFS_NUM_FLAGS-1:0] flag_arm;
  logic [RXFS_NUM_FLAGS-1:0] flag_clear_ev;

  for (genvar i = 0; i < RXFS_NUM_FLAGS; i++) begin : g_flag
    rxfs_flag #(.RST_VAL(flag_rst_val(i))) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (flag_set[i]),
      .rd_strobe (reg_rd),
      .wr_strobe (reg_wr),
      .wr_bit    (reg_wdata[flag_reg_bit(i)]),
      .flag      (flag_q[i]),
      .arm       (flag_arm[i]),
      .clear_ev  (flag_clear_ev[i])
    );
  end

  // status word assembly
  always_comb begin
    reg_rdata = '0;
    reg_rdata[REG_W-1 -: CNT_W]  = per_cnt;
    reg_rdata[8 +: CNT_W]        = fer_cnt;
    reg_rdata[3]                 = head_entry.ferr;
    reg_rdata[2]                 = head_entry.perr;
    for (int i = 0; i < RXFS_NUM_FLAGS; i++) begin
      reg_rdata[flag_reg_bit(i)] = flag_q[i];
    end
  end

endmodule

// File: rtl/rxfs_checker.sv
module rxfs_checker #(
  parameter int CNT_W = 4,
  parameter int NFL   = 6,
  localparam int REG_W = 2 * CNT_W + 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             pop_req,
  input logic             push_acc,
  input logic             pop_acc,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [NFL-1:0]   flag_set,
  input logic [NFL-1:0]   flag_q,
  input logic [NFL-1:0]   flag_arm,
  input logic [CNT_W-1:0] per_cnt,
  input logic [CNT_W-1:0] fer_cnt,
  input logic [REG_W-1:0] reg_rdata
);

  // R2
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_acc && !pop_acc) |=> ($stable(per_cnt) && $stable(fer_cnt)));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && push_valid) |-> !push_acc);

  // R1
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && pop_req) |-> !pop_acc);

  // R3
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (reg_rdata[3:2] == 2'b00));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

  // R5
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(flag_set)) == '0));

  // R6
  unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q & ~flag_arm) & ~flag_q) == '0));

  // R6
  arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_arm & ~flag_q) == '0));

endmodule

bind rx_fifo_status rxfs_checker #(.CNT_W(CNT_W), .NFL(rxfs_pkg::RXFS_NUM_FLAGS)) u_rxfs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .pop_req    (pop_req),
  .push_acc   (push_acc),
  .pop_acc    (pop_acc),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .flag_set   (flag_set),
  .flag_q     (flag_q),
  .flag_arm   (flag_arm),
  .per_cnt    (per_cnt),
  .fer_cnt    (fer_cnt),
  .reg_rdata  (reg_rdata)
);

// File: tb/rx_fifo_status_bench.sv
module rx_fifo_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic        push_perr = 1'b0;
  logic        push_ferr = 1'b0;
  logic        pop_req = 1'b0;
  logic [7:0]  pop_data;
  logic [5:0]  flag_set = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_status #(.DEPTH(DEPTH)) u_rx_fifo_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_perr  (push_perr),
    .push_ferr  (push_ferr),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .flag_set   (flag_set),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  // model: queue of {perr, ferr, data}
  logic [9:0] mq [DEPTH];
  int         mq_n = 0;
  logic [5:0] m_flag = 6'b011000;
  logic [5:0] m_arm  = '0;

  function automatic int pos_of(input int i);
    if (i == 0) return 0;
    if (i == 1) return 1;
    return i + 2;
  endfunction

  // counts rebuilt from scratch by scanning the queue
  function automatic logic [3:0] tally(input int which);
    int c;
    c = 0;
    for (int j = 0; j < mq_n; j++) c += mq[j][which];
    return 4'(c);
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = '0;
    s[15:12] = tally(9);
    s[11:8]  = tally(8);
    if (mq_n > 0) begin
      s[3] = mq[0][8];
      s[2] = mq[0][9];
    end
    for (int i = 0; i < 6; i++) s[pos_of(i)] = m_flag[i];
    return s;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic pv, input logic [7:0] pd, input logic pp, input logic pf,
                      input logic pr, input logic [5:0] fs, input logic rd,
                      input logic wr, input logic [15:0] wd);
    logic [15:0] es;
    bit          full0;
    bit          empty0;
    @(negedge clk);
    push_valid = pv; push_data = pd; push_perr = pp; push_ferr = pf;
    pop_req = pr; flag_set = fs; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    #1;
    es = exp_status();
    check("R1 pop_data", {8'h00, pop_data}, {8'h00, (mq_n > 0) ? mq[0][7:0] : 8'h00});
    check("R2 counts", {8'h00, reg_rdata[15:8]}, {8'h00, es[15:8]});
    check("R3 head tags", {14'h0, reg_rdata[3:2]}, {14'h0, es[3:2]});
    check("R6 flags", reg_rdata & 16'h00F3, es & 16'h00F3);
    // model update for the coming edge (R9: push and pop both apply)
    full0  = (mq_n == DEPTH);
    empty0 = (mq_n == 0);
    if (pr && !empty0) begin
      for (int j = 0; j < DEPTH - 1; j++) mq[j] = mq[j+1];
      mq_n--;
    end
    if (pv && !full0) begin
      mq[mq_n] = {pp, pf, pd};
      mq_n++;
    end
    for (int i = 0; i < 6; i++) begin
      if (fs[i]) begin                       // R4, R7
        m_flag[i] = 1'b1; m_arm[i] = 1'b0;
      end else if (wr && !wd[pos_of(i)] && m_arm[i]) begin
        m_flag[i] = 1'b0; m_arm[i] = 1'b0;
      end else if (rd && m_flag[i]) begin
        m_arm[i] = 1'b1;
      end
    end
    @(posedge clk);
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 0, 16'h0000);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check("R8 reset status", reg_rdata, 16'h0060);
    check("R8 reset pop_data", {8'h00, pop_data}, 16'h0000);
    rst_n = 1'b1;
    idle();

    // R5/R6: unarmed writes of 0 and writes of 1 change nothing
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 1, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 1, 16'hFFFF);
    // read then clear TEND and TDFE
    step(0, 8'h00, 0, 0, 0, 6'h00, 1, 0, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 1, 16'h0000);
    idle();
    // R7: armed clear with a coincident set pulse keeps ER
    step(0, 8'h00, 0, 0, 0, 6'h20, 0, 0, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h00, 1, 0, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h20, 0, 1, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 1, 16'h0000); // disarmed by the pulse
    step(0, 8'h00, 0, 0, 0, 6'h00, 1, 0, 16'h0000);
    step(0, 8'h00, 0, 0, 0, 6'h00, 0, 1, 16'hFF7F);
    idle();

    // R2: sixteen entries with both tags wrap the counts to zero; R1 drop
    for (int k = 0; k < DEPTH; k++) step(1, 8'(k + 8'h40), 1, 1, 0, 6'h00, 0, 0, 16'h0000);
    step(1, 8'hEE, 0, 0, 0, 6'h00, 0, 1, 16'h0000);
    step(1, 8'hEF, 1, 0, 1, 6'h00, 0, 0, 16'h0000); // full: push dropped, pop taken
    // R9: simultaneous push and pop
    for (int k = 0; k < 6; k++) step(1, 8'(k), k[0], k[1], 1, 6'h00, 0, 0, 16'h0000);
    for (int k = 0; k < DEPTH + 2; k++) step(0, 8'h00, 0, 0, 1, 6'h00, 0, 0, 16'h0000);
    idle();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 2) == 0, 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 5) < 2,
           {($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
            ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0},
           ($urandom % 10) < 3, ($urandom % 5) == 0, 16'($urandom));
    end
    idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule